// File: doc/BRIEF.md
# Secure Address Space Access Filter

This block stands in front of one memory or peripheral target and checks every access that reaches it against a table of security regions. Each request carries an address, a read/write flag, write data and a flag saying whether the requester is non-secure. A secure requester may reach any region. A non-secure requester may reach only regions classed as non-secure. A legal access goes to the target, and the target's response comes back to the requester. An illegal access never reaches the target. It is answered by the filter itself with an error. The check does not depend on any translation set up upstream, so badly programmed page tables cannot get around it.

The region table has two parts. Build-time regions come from parameters and cannot change; they are meant for the memory of a security processor. Run-time regions are meant for I/O windows. Each has a base, an inclusive limit, a non-secure bit and an enable bit, and is written through a plain configuration port that only honours secure writers. An address outside every region is treated as secure. A sticky record keeps the first blocked access until secure software clears it.

The requester side and the target side each use valid/ready channels. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only when no transaction is in flight, so the block handles one access at a time. The response stays valid and unchanged until `rsp_ready` is seen. Toward the target, `tgt_valid` and its payload hold until `tgt_ready`. The target's response is taken when `tgt_rsp_valid` and `tgt_rsp_ready` are both high.

Top module: `sec_access_filter`

## Requirements
- R1: A non-secure request to a region classed secure is blocked: no target request follows, and the response has `rsp_err`=1.
- R2: A secure request is forwarded to the target whether the region is secure or non-secure.
- R3: A non-secure request to a non-secure region is forwarded. For every forwarded access, the target's read data and error flag are returned unchanged on the response channel.
- R4: An address that matches no enabled region is classed secure.
- R5: Where a build-time region and a run-time region overlap, the build-time region's class decides.
- R6: A secure configuration write takes effect for requests accepted after it. The `cfg_sel` codes are 0=base, 1=limit, 2=attributes (`cfg_wdata[0]`=non-secure, `cfg_wdata[1]`=enable) and 3=clear violation. Among overlapping run-time regions, the lowest index decides.
- R7: A configuration write with `cfg_nonsec`=1 changes no region, leaves any logged violation uncleared, and raises `cfg_err` for exactly the next cycle.
- R8: A blocked access has `rsp_valid`=1 in the cycle after its acceptance, with `rsp_err`=1 and `rsp_rdata`=0.
- R9: The first blocked access sets `viol_valid` and logs its address, non-secure flag and write flag. Later blocked accesses leave the log unchanged until a secure clear (code 3) empties it.
- R10: `req_ready` is low while a transaction is in flight. The response and the target request hold steady while they are stalled.
- R11: After reset, `req_ready`=1, `rsp_valid`=0, `tgt_valid`=0, `viol_valid`=0 and `cfg_err`=0, and every run-time region is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_nonsec | input | 1 | Requester is non-secure |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DW | Read data (zero when blocked) |
| rsp_err | output | 1 | Error response |
| tgt_valid | output | 1 | Request to target valid |
| tgt_ready | input | 1 | Target accepts request |
| tgt_addr | output | AW | Address to target |
| tgt_write | output | 1 | Write flag to target |
| tgt_wdata | output | DW | Write data to target |
| tgt_rsp_valid | input | 1 | Target response valid |
| tgt_rsp_ready | output | 1 | Filter takes target response |
| tgt_rsp_rdata | input | DW | Target read data |
| tgt_rsp_err | input | 1 | Target error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_nonsec | input | 1 | Configuration writer is non-secure |
| cfg_idx | input | IDXW | Run-time region index |
| cfg_sel | input | 2 | Field code (see R6) |
| cfg_wdata | input | AW | Configuration data |
| cfg_err | output | 1 | Rejected configuration write, one cycle |
| viol_valid | output | 1 | Violation logged |
| viol_addr | output | AW | Logged address |
| viol_nonsec | output | 1 | Logged non-secure flag |
| viol_write | output | 1 | Logged write flag |

## Verification
The assertions rely on a well-behaved target. It must raise `tgt_rsp_valid` only once per forwarded request, and only after that request has been accepted. The stall checks rely on a requester that keeps `rsp_ready` and a target that keeps `tgt_ready` as plain levels, set away from the clock edge. The bench target model obeys this: it waits for a request, accepts it after two cycles, and answers once in the next cycle. The bench never issues a configuration clear in the same cycle as a blocked acceptance, so the logging rule in R9 is never ambiguous.

// File: rtl/saf_pkg.sv
package saf_pkg;
  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_LIMIT = 2'd1,
    CFG_ATTR  = 2'd2,
    CFG_CLEAR = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } txn_state_e;
endpackage

// File: rtl/saf_region_table.sv
module saf_region_table #(
  parameter int AW     = 32,
  parameter int N_PROG = 4,
  parameter int IDXW   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_nonsec,
  input  logic [IDXW-1:0]             cfg_idx,
  input  logic [1:0]                  cfg_sel,
  input  logic [AW-1:0]               cfg_wdata,
  output logic [N_PROG-1:0][AW-1:0]   prog_base,
  output logic [N_PROG-1:0][AW-1:0]   prog_limit,
  output logic [N_PROG-1:0]           prog_ns,
  output logic [N_PROG-1:0]           prog_en,
  output logic                        cfg_err,
  output logic                        clr_viol
);
  import saf_pkg::*;

  logic     wr_ok;
  cfg_sel_e sel;

  assign sel      = cfg_sel_e'(cfg_sel);
  assign wr_ok    = cfg_we && !cfg_nonsec;
  assign clr_viol = wr_ok && (sel == CFG_CLEAR);

  for (genvar g = 0; g < N_PROG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prog_base[g]  <= '0;
        prog_limit[g] <= '0;
        prog_ns[g]    <= 1'b0;
        prog_en[g]    <= 1'b0;
      end else if (wr_ok && (cfg_idx == IDXW'(g))) begin
        case (sel)
          CFG_BASE:  prog_base[g]  <= cfg_wdata;
          CFG_LIMIT: prog_limit[g] <= cfg_wdata;
          CFG_ATTR: begin
            prog_ns[g] <= cfg_wdata[0];
            prog_en[g] <= cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_we && cfg_nonsec;
  end

  a_r7_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_nonsec) |=> ($stable(prog_base) && $stable(prog_limit)
                                && $stable(prog_ns) && $stable(prog_en)));
  a_r7_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_nonsec) |=> cfg_err);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_nonsec) |=> !cfg_err);
endmodule

// File: rtl/saf_region_classify.sv
module saf_region_classify #(
  parameter int              AW        = 32,
  parameter int              N_FIX     = 2,
  parameter int              N_PROG    = 4,
  parameter logic [N_FIX*AW-1:0] FIX_BASE  = '0,
  parameter logic [N_FIX*AW-1:0] FIX_LIMIT = '0,
  parameter logic [N_FIX-1:0]    FIX_NS    = '0
) (
  input  logic [AW-1:0]               addr,
  input  logic [N_PROG-1:0][AW-1:0]   prog_base,
  input  logic [N_PROG-1:0][AW-1:0]   prog_limit,
  input  logic [N_PROG-1:0]           prog_ns,
  input  logic [N_PROG-1:0]           prog_en,
  output logic                        region_ns
);
  logic [N_FIX-1:0]  fix_hit;
  logic [N_PROG-1:0] prog_hit;

  // offset-from-base compare: one subtractor and one comparator per fixed region
  for (genvar g = 0; g < N_FIX; g++) begin : g_fix
    localparam logic [AW-1:0] BASE_G = FIX_BASE[g*AW +: AW];
    localparam logic [AW-1:0] SPAN_G = FIX_LIMIT[g*AW +: AW] - FIX_BASE[g*AW +: AW];
    logic [AW-1:0] offs;
    assign offs       = addr - BASE_G;
    assign fix_hit[g] = (offs <= SPAN_G);
  end

  for (genvar g = 0; g < N_PROG; g++) begin : g_prog
    assign prog_hit[g] = prog_en[g] && (addr >= prog_base[g]) && (addr <= prog_limit[g]);
  end

  // lowest priority first: default secure, then run-time, then build-time
  always_comb begin
    region_ns = 1'b0;
    for (int i = N_PROG - 1; i >= 0; i--) begin
      if (prog_hit[i]) region_ns = prog_ns[i];
    end
    for (int i = N_FIX - 1; i >= 0; i--) begin
      if (fix_hit[i]) region_ns = FIX_NS[i];
    end
  end
endmodule

// File: rtl/saf_txn_ctrl.sv
module saf_txn_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_allow,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          tgt_valid,
  input  logic          tgt_ready,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_write,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_rsp_valid,
  output logic          tgt_rsp_ready,
  input  logic [DW-1:0] tgt_rsp_rdata,
  input  logic          tgt_rsp_err
);
  import saf_pkg::*;

  txn_state_e    state;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          err_q;

  assign req_ready     = (state == ST_IDLE);
  assign tgt_valid     = (state == ST_FWD);
  assign tgt_rsp_ready = (state == ST_WAIT);
  assign rsp_valid     = (state == ST_RSP);
  assign tgt_addr      = addr_q;
  assign tgt_write     = write_q;
  assign tgt_wdata     = wdata_q;
  assign rsp_rdata     = rdata_q;
  assign rsp_err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          write_q <= req_write;
          wdata_q <= req_wdata;
          if (req_allow) begin
            state <= ST_FWD;
          end else begin
            rdata_q <= '0;
            err_q   <= 1'b1;
            state   <= ST_RSP;
          end
        end
        ST_FWD:  if (tgt_ready) state <= ST_WAIT;
        ST_WAIT: if (tgt_rsp_valid) begin
          rdata_q <= tgt_rsp_rdata;
          err_q   <= tgt_rsp_err;
          state   <= ST_RSP;
        end
        ST_RSP:  if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r8_block_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_allow) |=> (rsp_valid && rsp_err && (rsp_rdata == '0)));
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  a_r10_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_addr) && $stable(tgt_write)
                                   && $stable(tgt_wdata)));
  a_r10_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/saf_viol_log.sv
module saf_viol_log #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk,
  input  logic [AW-1:0] blk_addr,
  input  logic          blk_nonsec,
  input  logic          blk_write,
  input  logic          clr,
  output logic          viol_valid,
  output logic [AW-1:0] viol_addr,
  output logic          viol_nonsec,
  output logic          viol_write
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid  <= 1'b0;
      viol_addr   <= '0;
      viol_nonsec <= 1'b0;
      viol_write  <= 1'b0;
    end else begin
      if (clr) viol_valid <= 1'b0;
      if (blk && (!viol_valid || clr)) begin
        viol_valid  <= 1'b1;
        viol_addr   <= blk_addr;
        viol_nonsec <= blk_nonsec;
        viol_write  <= blk_write;
      end
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !clr) |=> (viol_valid && $stable(viol_addr) && $stable(viol_nonsec)
                              && $stable(viol_write)));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !viol_valid) |=> (viol_valid && (viol_addr == $past(blk_addr))));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !blk) |=> !viol_valid);
endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter #(
  parameter int                  AW        = 32,
  parameter int                  DW        = 32,
  parameter int                  N_FIX     = 2,
  parameter int                  N_PROG    = 4,
  parameter logic [N_FIX*AW-1:0] FIX_BASE  = {32'h0001_0000, 32'h0000_0000},
  parameter logic [N_FIX*AW-1:0] FIX_LIMIT = {32'h0001_FFFF, 32'h0000_FFFF},
  parameter logic [N_FIX-1:0]    FIX_NS    = 2'b10,
  localparam int                 IDXW      = (N_PROG > 1) ? $clog2(N_PROG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_nonsec,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            tgt_valid,
  input  logic            tgt_ready,
  output logic [AW-1:0]   tgt_addr,
  output logic            tgt_write,
  output logic [DW-1:0]   tgt_wdata,
  input  logic            tgt_rsp_valid,
  output logic            tgt_rsp_ready,
  input  logic [DW-1:0]   tgt_rsp_rdata,
  input  logic            tgt_rsp_err,
  input  logic            cfg_we,
  input  logic            cfg_nonsec,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            cfg_err,
  output logic            viol_valid,
  output logic [AW-1:0]   viol_addr,
  output logic            viol_nonsec,
  output logic            viol_write
);
  logic [N_PROG-1:0][AW-1:0] prog_base;
  logic [N_PROG-1:0][AW-1:0] prog_limit;
  logic [N_PROG-1:0]         prog_ns;
  logic [N_PROG-1:0]         prog_en;
  logic                      clr_viol;
  logic                      region_ns;
  logic                      allow;
  logic                      blk_acc;

  saf_region_table #(.AW(AW), .N_PROG(N_PROG), .IDXW(IDXW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_nonsec(cfg_nonsec),
    .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .prog_base(prog_base), .prog_limit(prog_limit), .prog_ns(prog_ns),
    .prog_en(prog_en), .cfg_err(cfg_err), .clr_viol(clr_viol)
  );

  saf_region_classify #(
    .AW(AW), .N_FIX(N_FIX), .N_PROG(N_PROG),
    .FIX_BASE(FIX_BASE), .FIX_LIMIT(FIX_LIMIT), .FIX_NS(FIX_NS)
  ) u_classify (
    .addr(req_addr), .prog_base(prog_base), .prog_limit(prog_limit),
    .prog_ns(prog_ns), .prog_en(prog_en), .region_ns(region_ns)
  );

  assign allow   = !req_nonsec || region_ns;
  assign blk_acc = req_valid && req_ready && !allow;

  saf_txn_ctrl #(.AW(AW), .DW(DW)) u_txn (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_allow(allow),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
    .tgt_write(tgt_write), .tgt_wdata(tgt_wdata),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_ready(tgt_rsp_ready),
    .tgt_rsp_rdata(tgt_rsp_rdata), .tgt_rsp_err(tgt_rsp_err)
  );

  saf_viol_log #(.AW(AW)) u_viol (
    .clk(clk), .rst_n(rst_n), .blk(blk_acc), .blk_addr(req_addr),
    .blk_nonsec(req_nonsec), .blk_write(req_write), .clr(clr_viol),
    .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_nonsec(viol_nonsec),
    .viol_write(viol_write)
  );

  a_r1_ns_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_nonsec && !region_ns) |=> (!tgt_valid && rsp_err));
  a_r2_secure_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_nonsec) |=> tgt_valid);
  a_r3_ns_region_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_nonsec && region_ns) |=> tgt_valid);
endmodule

// File: tb/sec_access_filter_tb_top.sv
`timescale 1ns/1ps
module sec_access_filter_tb_top;
  localparam logic [31:0] RD_MASK = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_nonsec = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        tgt_valid, tgt_write, tgt_rsp_ready;
  logic [31:0] tgt_addr, tgt_wdata;
  logic        tgt_ready = 1'b0, tgt_rsp_valid = 1'b0, tgt_rsp_err = 1'b0;
  logic [31:0] tgt_rsp_rdata = '0;
  logic        cfg_we = 1'b0, cfg_nonsec = 1'b0;
  logic [1:0]  cfg_idx = '0, cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_err, viol_valid, viol_nonsec, viol_write;
  logic [31:0] viol_addr;

  int checks = 0;
  int errors = 0;
  int tgt_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    bit          fwd;
    int          tgt_start;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  sec_access_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_nonsec(req_nonsec),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
    .tgt_write(tgt_write), .tgt_wdata(tgt_wdata),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_ready(tgt_rsp_ready),
    .tgt_rsp_rdata(tgt_rsp_rdata), .tgt_rsp_err(tgt_rsp_err),
    .cfg_we(cfg_we), .cfg_nonsec(cfg_nonsec), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
    .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_nonsec(viol_nonsec),
    .viol_write(viol_write)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // target model: accepts after two cycles, answers once in the following cycle
  initial begin
    logic [31:0] a;
    logic        w;
    forever begin
      @(negedge clk);
      tgt_rsp_valid = 1'b0;
      if (rst_n && tgt_valid) begin
        repeat (2) @(negedge clk);
        tgt_ready = 1'b1;
        a = tgt_addr;
        w = tgt_write;
        tgt_cnt++;
        @(negedge clk);
        tgt_ready     = 1'b0;
        tgt_rsp_valid = 1'b1;
        tgt_rsp_rdata = w ? 32'h0 : (a ^ RD_MASK);
        tgt_rsp_err   = (a[31:28] == 4'hF);
      end
    end
  end

  // monitor: pops the scoreboard on each response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_rdata === e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
        chk(rsp_err === e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
        chk((tgt_cnt - e.tgt_start) == (e.fwd ? 1 : 0), {e.tag, " forwarded"},
            32'(tgt_cnt - e.tgt_start), e.fwd ? 32'h1 : 32'h0);
      end
    end
  end

  task automatic do_req(input logic [31:0] a, input bit w, input bit ns, input bit fwd,
                        input string tag);
    exp_t e;
    e.fwd       = fwd;
    e.rdata     = fwd ? (w ? 32'h0 : (a ^ RD_MASK)) : 32'h0;
    e.err       = fwd ? (a[31:28] == 4'hF) : 1'b1;
    e.tgt_start = tgt_cnt;
    e.tag       = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_write  = w;
    req_wdata  = a ^ 32'h0000_1111;
    req_nonsec = ns;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 32'h0);
    if (!fwd) chk(rsp_valid === 1'b1, "R8 next-cycle answer", 32'(rsp_valid), 32'h1);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg_write(input int idx, input logic [1:0] sel, input logic [31:0] d,
                           input bit ns);
    @(negedge clk);
    cfg_we     = 1'b1;
    cfg_nonsec = ns;
    cfg_idx    = 2'(idx);
    cfg_sel    = sel;
    cfg_wdata  = d;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err === ns, "R7 cfg_err", 32'(cfg_err), 32'(ns));
    @(negedge clk);
    chk(cfg_err === 1'b0, "R7 cfg_err one cycle", 32'(cfg_err), 32'h0);
  endtask

  task automatic prog_region(input int idx, input logic [31:0] b, input logic [31:0] l,
                             input bit ns);
    cfg_write(idx, 2'd0, b, 1'b0);
    cfg_write(idx, 2'd1, l, 1'b0);
    cfg_write(idx, 2'd2, {30'h0, 1'b1, ns}, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11 req_ready", 32'(req_ready), 32'h1);
    chk(rsp_valid === 1'b0, "R11 rsp_valid", 32'(rsp_valid), 32'h0);
    chk(tgt_valid === 1'b0, "R11 tgt_valid", 32'(tgt_valid), 32'h0);
    chk(viol_valid === 1'b0, "R11 viol_valid", 32'(viol_valid), 32'h0);
    chk(cfg_err === 1'b0, "R11 cfg_err", 32'(cfg_err), 32'h0);
    // R11: run-time regions disabled, so 0x4000_0000 is unmatched and secure
    do_req(32'h4000_0000, 1'b0, 1'b1, 1'b0, "R11 regions off");

    // R9: first violation logged
    chk(viol_valid === 1'b1, "R9 logged", 32'(viol_valid), 32'h1);
    chk(viol_addr === 32'h4000_0000, "R9 addr", viol_addr, 32'h4000_0000);
    chk(viol_nonsec === 1'b1, "R9 nonsec", 32'(viol_nonsec), 32'h1);

    do_req(32'h0000_0100, 1'b0, 1'b1, 1'b0, "R1 ns to fixed secure");
    do_req(32'h0000_0100, 1'b0, 1'b0, 1'b1, "R2 secure to secure");
    do_req(32'h0001_0004, 1'b0, 1'b1, 1'b1, "R3 ns to ns");
    do_req(32'h0001_0008, 1'b1, 1'b0, 1'b1, "R2 secure write to ns");
    do_req(32'h2000_0000, 1'b1, 1'b1, 1'b0, "R4 unmatched blocked");
    do_req(32'h2000_0000, 1'b0, 1'b0, 1'b1, "R4 unmatched secure ok");
    do_req(32'hF000_0010, 1'b0, 1'b0, 1'b1, "R3 target error relayed");
    chk(viol_addr === 32'h4000_0000, "R9 sticky", viol_addr, 32'h4000_0000);

    // R6: program region 0 as non-secure window
    prog_region(0, 32'h4000_0000, 32'h4000_0FFF, 1'b1);
    do_req(32'h4000_0010, 1'b0, 1'b1, 1'b1, "R6 programmed ns window");
    // R7: non-secure attempt to reclassify region 0 is ignored
    cfg_write(0, 2'd2, 32'h2, 1'b1);
    do_req(32'h4000_0020, 1'b0, 1'b1, 1'b1, "R7 ns cfg ignored");
    // R5: overlaps with fixed regions
    prog_region(1, 32'h0000_8000, 32'h0000_80FF, 1'b1);
    do_req(32'h0000_8010, 1'b0, 1'b1, 1'b0, "R5 fixed secure wins");
    prog_region(3, 32'h0001_0000, 32'h0001_00FF, 1'b0);
    do_req(32'h0001_0010, 1'b0, 1'b1, 1'b1, "R5 fixed ns wins");
    // R6: lowest index among run-time regions
    prog_region(2, 32'h4000_0000, 32'h4000_FFFF, 1'b0);
    do_req(32'h4000_0040, 1'b0, 1'b1, 1'b1, "R6 low index wins");
    do_req(32'h4000_1000, 1'b0, 1'b1, 1'b0, "R6 secure run-time region");

    // R7/R9: non-secure clear ignored, secure clear works
    cfg_write(0, 2'd3, 32'h0, 1'b1);
    chk(viol_valid === 1'b1, "R7 ns clear ignored", 32'(viol_valid), 32'h1);
    cfg_write(0, 2'd3, 32'h0, 1'b0);
    chk(viol_valid === 1'b0, "R9 cleared", 32'(viol_valid), 32'h0);
    do_req(32'h5000_0000, 1'b1, 1'b1, 1'b0, "R8 blocked write");
    chk(viol_addr === 32'h5000_0000, "R9 recapture addr", viol_addr, 32'h5000_0000);
    chk(viol_write === 1'b1, "R9 recapture write", 32'(viol_write), 32'h1);

    // R10: response back-pressure
    rsp_ready = 1'b0;
    fork
      do_req(32'h0001_0040, 1'b0, 1'b1, 1'b1, "R10 stalled response");
      begin
        while (!rsp_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b1, "R10 response held", 32'(rsp_valid), 32'h1);
        chk(rsp_rdata === (32'h0001_0040 ^ RD_MASK), "R10 data held", rsp_rdata,
            32'h0001_0040 ^ RD_MASK);
        rsp_ready = 1'b1;
      end
    join
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule